// File: doc/BRIEF.md
# Prescaled Match Timer

A 32-bit timer for a peripheral clock domain. A prescale counter divides the clock, and a timer count advances once each time the prescaler completes a period. Four match channels compare their own 32-bit value against the timer count. Each channel has a 3-bit action field. A match can raise a latched interrupt flag, return the count to zero, or halt counting. Software uses a plain word-addressed read/write bus to set the prescale limit, the match values, the action fields and the run bit. It clears pending flags by writing ones to them.

The block serves periodic ticks (match plus reset), one-shot delays (match plus stop) and timestamping (free run with a readable count). The interrupt line is high while any flag is pending.

Top module: `match_timer`

## Requirements
- R1: After reset the run bit, prescale limit, prescale count, timer count, action fields, flags and all match values read 0, and `irqOut` is low.
- R2: With the run bit set by a write at clock edge 0 and prescale limit P, the timer count after edge k equals floor(k/(P+1)), and the prescale count equals k mod (P+1).
- R3: While the run bit is 0, neither the prescale count nor the timer count changes.
- R4: A channel matches once per timer count value. The match is taken on the edge after the count takes a value equal to the channel's match value. Holding that value for more prescale clocks does not match again.
- R5: Action bit 1 of a matching channel makes both counts 0 on the match edge. That edge takes precedence over a prescale step in the same cycle.
- R6: Action bit 2 of a matching channel clears the run bit on the match edge. The count stays at the match value.
- R7: Action bit 0 of a matching channel sets flag bit i (register 5, bit i = channel i). `irqOut` is the OR of all flag bits.
- R8: Writing register 5 clears each flag whose data bit is 1. Zero bits leave their flags unchanged, and a new match on the same edge wins over the clear.
- R9: The action register (register 4) holds 3 bits per channel at bits 3i+2..3i: bit 0 interrupt, bit 1 zero, bit 2 stop. The bits above 11 read 0.
- R10: The register map is word addresses: 0 run bit (bit 0), 1 prescale limit, 2 prescale count (read only), 3 timer count (read only), 4 action fields, 5 flags, 8 to 11 match values of channels 0 to 3. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Word address of the register accessed |
| busWrite | input | 1 | Write strobe, sampled on the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | High while any match flag is pending |

## Verification
A prescale count that drifts shows at the timer count read back within one prescale period. A wrong prescale count also shifts every later match edge, so `irqOut` moves by whole clocks. A freshness marker that stays set would re-raise a flag cleared while the count is still held at the match value; the bench samples this in the very next cycle. A lost reset or stop action appears on the edge after the match as a nonzero count or a run bit still set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W   = 32;
  localparam int NUM_CH  = 4;
  localparam int ACT_W   = 3;
  localparam int ADDR_W  = 4;
  localparam int MCR_W   = ACT_W * NUM_CH;

  localparam logic [ADDR_W-1:0] A_RUN    = 4'd0;
  localparam logic [ADDR_W-1:0] A_PRESC  = 4'd1;
  localparam logic [ADDR_W-1:0] A_PCNT   = 4'd2;
  localparam logic [ADDR_W-1:0] A_TCNT   = 4'd3;
  localparam logic [ADDR_W-1:0] A_ACTION = 4'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd5;
  localparam logic [ADDR_W-1:0] A_MATCH0 = 4'd8;

  localparam int ACT_INT  = 0;
  localparam int ACT_ZERO = 1;
  localparam int ACT_STOP = 2;

  typedef struct packed {
    logic run;
    logic zero;
  } dpStrobe_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int NC = NUM_CH
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic [CW-1:0]          prescaleLim,
  input  logic [NC-1:0][CW-1:0]  matchVal,
  output logic [CW-1:0]          preCount,
  output logic [CW-1:0]          timerCount,
  output logic [NC-1:0]          hitVec
);
  logic fresh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCount   <= '0;
      timerCount <= '0;
      fresh      <= 1'b0;
    end else begin
      fresh <= 1'b0;
      if (strobe.zero) begin
        preCount   <= '0;
        timerCount <= '0;
      end else if (strobe.run) begin
        if (preCount >= prescaleLim) begin
          preCount   <= '0;
          timerCount <= timerCount + 1'b1;
          fresh      <= 1'b1;
        end else begin
          preCount <= preCount + 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < NC; i++) begin : g_cmp
    assign hitVec[i] = fresh && (timerCount == matchVal[i]);

    a_r4_single_hit: assert property (@(posedge clk) disable iff (!rstN)
      hitVec[i] |=> !hitVec[i]);
  end

  a_r5_zero_counts: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zero |=> (timerCount == '0) && (preCount == '0));

  a_r3_hold_counts: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.zero) |=> $stable(timerCount) && $stable(preCount));
endmodule

// File: rtl/tmr_control.sv
module tmr_control
  import tmr_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int NC = NUM_CH,
  parameter int AW = ADDR_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [AW-1:0]          busAddr,
  input  logic                   busWrite,
  input  logic [CW-1:0]          busWdata,
  output logic [CW-1:0]          busRdata,
  output logic                   irqOut,
  input  logic [NC-1:0]          hitVec,
  input  logic [CW-1:0]          preCount,
  input  logic [CW-1:0]          timerCount,
  output dpStrobe_t              strobe,
  output logic [CW-1:0]          prescaleLim,
  output logic [NC-1:0][CW-1:0]  matchVal
);
  localparam int AF_W = ACT_W * NC;

  logic            runBit;
  logic [AF_W-1:0] actField;
  logic [NC-1:0]   flags;
  logic [NC-1:0]   intHit, zeroHitV, stopHitV;
  logic            zeroHit, stopHit;
  logic            wrRun, wrPresc, wrAction, wrFlags;

  assign wrRun    = busWrite && (busAddr == A_RUN);
  assign wrPresc  = busWrite && (busAddr == A_PRESC);
  assign wrAction = busWrite && (busAddr == A_ACTION);
  assign wrFlags  = busWrite && (busAddr == A_FLAGS);

  for (genvar i = 0; i < NC; i++) begin : g_ch
    logic [ACT_W-1:0] act;
    assign act         = actField[ACT_W*i +: ACT_W];
    assign intHit[i]   = hitVec[i] && act[ACT_INT];
    assign zeroHitV[i] = hitVec[i] && act[ACT_ZERO];
    assign stopHitV[i] = hitVec[i] && act[ACT_STOP];

    always_ff @(posedge clk) begin
      if (!rstN) matchVal[i] <= '0;
      else if (busWrite && (busAddr == A_MATCH0 + AW'(i))) matchVal[i] <= busWdata;
    end

    a_r8_w1c_clear: assert property (@(posedge clk) disable iff (!rstN)
      (wrFlags && busWdata[i] && !intHit[i]) |=> !flags[i]);
    a_r7_flag_set: assert property (@(posedge clk) disable iff (!rstN)
      intHit[i] |=> flags[i] && irqOut);
  end

  assign zeroHit     = |zeroHitV;
  assign stopHit     = |stopHitV;
  assign strobe.zero = zeroHit;
  assign strobe.run  = runBit && !stopHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit      <= 1'b0;
      prescaleLim <= '0;
      actField    <= '0;
      flags       <= '0;
    end else begin
      if (stopHit)    runBit <= 1'b0;
      else if (wrRun) runBit <= busWdata[0];
      if (wrPresc)  prescaleLim <= busWdata;
      if (wrAction) actField    <= busWdata[AF_W-1:0];
      flags <= (flags & ~(wrFlags ? busWdata[NC-1:0] : '0)) | intHit;
    end
  end

  assign irqOut = |flags;

  always_comb begin
    busRdata = '0;
    if (busAddr == A_RUN)         busRdata[0] = runBit;
    else if (busAddr == A_PRESC)  busRdata = prescaleLim;
    else if (busAddr == A_PCNT)   busRdata = preCount;
    else if (busAddr == A_TCNT)   busRdata = timerCount;
    else if (busAddr == A_ACTION) busRdata[AF_W-1:0] = actField;
    else if (busAddr == A_FLAGS)  busRdata[NC-1:0] = flags;
    else begin
      for (int i = 0; i < NC; i++)
        if (busAddr == A_MATCH0 + AW'(i)) busRdata = matchVal[i];
    end
  end

  a_r6_stop_clears_run: assert property (@(posedge clk) disable iff (!rstN)
    stopHit |=> !runBit);
endmodule

// File: rtl/match_timer.sv
module match_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic              irqOut
);
  dpStrobe_t                    strobe;
  logic [CNT_W-1:0]             prescaleLim, preCount, timerCount;
  logic [NUM_CH-1:0][CNT_W-1:0] matchVal;
  logic [NUM_CH-1:0]            hitVec;

  tmr_control #(.CW(CNT_W), .NC(NUM_CH), .AW(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .hitVec(hitVec), .preCount(preCount), .timerCount(timerCount),
    .strobe(strobe), .prescaleLim(prescaleLim), .matchVal(matchVal)
  );

  tmr_datapath #(.CW(CNT_W), .NC(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .prescaleLim(prescaleLim),
    .matchVal(matchVal), .preCount(preCount), .timerCount(timerCount),
    .hitVec(hitVec)
  );
endmodule

// File: tb/tb_match_timer.sv
module tb_match_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  match_timer dut (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
                   .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [3:0] a, input logic [31:0] exp);
    busAddr = a; #1;
    check(req, busRdata, exp);
  endtask

  task automatic waitEdges(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    waitEdges(3);
    for (int a = 0; a < 12; a++) rdChk("R1 reset value", 4'(a), 32'h0);
    check("R1 irq low", {31'b0, irqOut}, 32'h0);
    rdChk("R3 held while stopped", 4'd3, 32'h0);
  endtask

  task automatic testPrescale(input int p, input int k);
    doReset();
    wr(4'd1, p);
    wr(4'd0, 32'h1);
    waitEdges(k);
    rdChk("R2 timer count", 4'd3, k / (p + 1));
    rdChk("R2 prescale count", 4'd2, k % (p + 1));
  endtask

  task automatic testZeroAction();
    doReset();
    wr(4'd1, 32'd2);
    wr(4'd8, 32'd6);
    wr(4'd4, 32'h3);
    wr(4'd0, 32'h1);
    waitEdges(18);
    rdChk("R5 count at match value", 4'd3, 32'd6);
    check("R7 irq not yet", {31'b0, irqOut}, 32'h0);
    waitEdges(1);
    rdChk("R5 count zeroed", 4'd3, 32'd0);
    rdChk("R5 prescale zeroed", 4'd2, 32'd0);
    check("R7 irq raised", {31'b0, irqOut}, 32'h1);
    waitEdges(3);
    rdChk("R5 restart", 4'd3, 32'd1);
  endtask

  task automatic testStopAction();
    doReset();
    wr(4'd9, 32'd4);
    wr(4'd4, 32'h20);
    wr(4'd0, 32'h1);
    waitEdges(6);
    rdChk("R6 count held at match", 4'd3, 32'd4);
    rdChk("R6 run bit cleared", 4'd0, 32'd0);
    rdChk("R7 no flag without int bit", 4'd5, 32'd0);
    check("R7 irq low", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic testOncePerValue();
    doReset();
    wr(4'd1, 32'd3);
    wr(4'd10, 32'd2);
    wr(4'd4, 32'h40);
    wr(4'd0, 32'h1);
    waitEdges(9);
    rdChk("R7 channel 2 flag", 4'd5, 32'h4);
    wr(4'd5, 32'h4);
    rdChk("R8 write one clears", 4'd5, 32'h0);
    check("R8 irq low after clear", {31'b0, irqOut}, 32'h0);
    wr(4'd5, 32'h0);
    rdChk("R4 count still held", 4'd3, 32'd2);
    rdChk("R4 no second match", 4'd5, 32'h0);
  endtask

  task automatic testTwoFlags();
    doReset();
    wr(4'd8, 32'd2);
    wr(4'd9, 32'd3);
    wr(4'd4, 32'h9);
    wr(4'd0, 32'h1);
    waitEdges(4);
    rdChk("R7 both flags", 4'd5, 32'h3);
    wr(4'd5, 32'h0);
    rdChk("R8 zero write no effect", 4'd5, 32'h3);
    wr(4'd5, 32'h1);
    rdChk("R8 clear only bit 0", 4'd5, 32'h2);
    check("R7 irq is OR", {31'b0, irqOut}, 32'h1);
    wr(4'd5, 32'h2);
    check("R7 irq low when none", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic testMap();
    doReset();
    wr(4'd4, 32'hFFFF_FFFF);
    rdChk("R9 reserved action bits", 4'd4, 32'h0000_0FFF);
    wr(4'd11, 32'hA5A5_0F0F);
    rdChk("R10 match 3 readback", 4'd11, 32'hA5A5_0F0F);
    rdChk("R10 unused address", 4'd7, 32'h0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    testPrescale(0, 5);
    testPrescale(1, 7);
    testPrescale(3, 10);
    testZeroAction();
    testStopAction();
    testOncePerValue();
    testTwoFlags();
    testMap();
    finishRun();
  end
endmodule